// File: doc/BRIEF.md
# Receive Descriptor Ring Manager

This block runs the receive side of a network controller's descriptor handling. The host builds a ring of 16-byte descriptors in its memory. Each descriptor is four 32-bit words:

- a control word;
- an unused word;
- the low half of a buffer address;
- the high half of that address.

Once started on a ring base, the engine takes one frame at a time. For each frame it reads the current descriptor and checks that the controller owns it. It then hands the buffer address and the byte count to the write DMA. When the DMA reports completion, it writes the control word back with ownership returned to the host.

The ring wraps when a descriptor carries the end-of-ring flag, not when a count runs out. If the engine reads a descriptor that the host still owns, it raises a one-cycle descriptor-unavailable interrupt and halts. It resumes on a restart pulse by reading that same descriptor again, and the frame that was waiting is delivered then.

Frames whose length exceeds the configured receive limit are discarded before any memory traffic. A limit of zero discards every frame. Memory is reached through a single request/acknowledge port that carries both reads and writes.

Top module: `rx_ring_mgr`

## Requirements
- R1: A start pulse with a ring base whose low 8 bits are not zero sets `base_err` and leaves the engine stopped (`frm_ready` low, no memory request). A start pulse with an aligned base clears `base_err` and makes `frm_ready` high.
- R2: An offered frame whose `frm_len` exceeds `max_rx_len`, or any frame while `max_rx_len` is zero, is consumed with a one-cycle `frm_drop` pulse and causes no memory request.
- R3: An accepted frame first reads the control word at the descriptor address. If bit 31 (owned by the controller) is 1, the engine reads offset +8 (buffer address low) and offset +12 (buffer address high). It then holds `dma_req` with `dma_addr` = {high, low} until `dma_done`.
- R4: A memory request holds `mem_req`, `mem_addr` and `mem_we` stable until `mem_ack`.
- R5: After `dma_done`, the control word is written at the descriptor address as follows:
  - bit 31 = 0;
  - bit 30 = the end-of-ring bit that was read;
  - bit 21 = the truncation flag;
  - bits 13:0 = the byte count given to the DMA;
  - all other bits 0.
- R6: The buffer size is bits 13:0 of the control word. A frame longer than that size is cut to the buffer size in `dma_len`, and the truncation flag is set. A frame of exactly the buffer size is not truncated.
- R7: The next descriptor is at +16 from the current one. After a descriptor with bit 30 set, the next one is the ring base.
- R8: A control word with bit 31 clear produces a one-cycle `rdu_irq` pulse and sets `halted`. While halted there is no memory request, no DMA request and `frm_ready` is low.
- R9: A `restart` pulse while halted clears `halted` and rereads the same descriptor. The pending frame is then completed into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse: begin using the ring at `ring_base` |
| ring_base | input | ADDR_W | Ring base address (256-byte aligned) |
| max_rx_len | input | 14 | Largest frame accepted, in bytes |
| restart | input | 1 | Pulse: leave halt and refetch |
| frm_valid | input | 1 | A frame of `frm_len` bytes is offered |
| frm_len | input | 14 | Length of the offered frame |
| frm_ready | output | 1 | Engine can take a frame |
| frm_drop | output | 1 | Pulse: the frame was discarded |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| dma_req | output | 1 | Buffer handed to the write DMA |
| dma_addr | output | 64 | Buffer address |
| dma_len | output | 14 | Bytes the DMA may write |
| dma_done | input | 1 | DMA finished the buffer |
| rdu_irq | output | 1 | Pulse: descriptor unavailable |
| halted | output | 1 | Engine stopped on a host-owned descriptor |
| base_err | output | 1 | Last start had a misaligned base |

## Verification
The bench goes after four corner cases.

- **Ring wrap.** It walks a three-entry ring whose last entry carries the end-of-ring flag and places an owned decoy entry just past it. A design that counted descriptors instead of honouring the flag would write into the decoy.
- **Truncation boundaries.** It offers frames one byte over, exactly at and under the buffer size, and one exactly at the receive limit. An off-by-one in truncation or in admission would show up as a wrong DMA length, a wrong status flag or a stray drop.
- **Halt and restart.** A host-owned descriptor must stop all traffic. After restart the same descriptor must be reused. A design that advanced past it, or lost the waiting frame, would produce a write at the wrong address or none at all.
- **Refused frames and bad base.** A zero limit and a misaligned base must each leave the memory port silent.

// File: rtl/rxr_pkg.sv
// Shared definitions for the receive descriptor ring manager.
// Assumes 16-byte descriptors of four 32-bit little-endian-ordered words.
package rxr_pkg;
    localparam int LEN_W     = 14;   // byte-count field width
    localparam int OWN_BIT   = 31;   // 1 = controller owns the descriptor
    localparam int EOR_BIT   = 30;   // last descriptor in the ring
    localparam int TRUNC_BIT = 21;   // written-back truncation flag
    localparam int BUF_AW    = 64;   // buffer address width
    localparam int DESC_SH   = 4;    // log2 of descriptor size in bytes
    localparam int ALIGN_SH  = 8;    // log2 of ring base alignment

    typedef enum logic [2:0] {
        S_OFF, S_IDLE, S_RD0, S_RDL, S_RDH, S_DMA, S_WB, S_HALT
    } rxr_state_t;
endpackage

// File: rtl/rxr_admit.sv
// Frame admission: decides whether an offered frame fits the receive limit.
// Assumes the limit is stable while a frame is offered.
module rxr_admit
    import rxr_pkg::*;
(
    input  logic [LEN_W-1:0] frm_len,
    input  logic [LEN_W-1:0] max_len,
    output logic             ok
);
    // Accept only when a limit is set and the frame does not exceed it.
    always_comb ok = (max_len != '0) && (frm_len <= max_len);
endmodule

// File: rtl/rxr_ring_ptr.sv
// Ring position keeper: holds the ring base and the current descriptor index
// and forms the byte address of the current descriptor.
// Assumes the base is 256-byte aligned when loaded.
module rxr_ring_ptr
    import rxr_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int MAX_DESC = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              advance,
    input  logic              wrap,
    output logic [ADDR_W-1:0] desc_addr
);
    localparam int IDX_W = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1;

    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  idx_q;

    // Load the base on start; step or return to the base after each descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            base_q <= base_in;
            idx_q  <= '0;
        end else if (advance) begin
            if (wrap || idx_q == IDX_W'(MAX_DESC - 1))
                idx_q <= '0;
            else
                idx_q <= idx_q + 1'b1;
        end
    end

    // Descriptor address is the base plus index times sixteen.
    always_comb desc_addr = base_q + (ADDR_W'(idx_q) << DESC_SH);
endmodule

// File: rtl/rxr_wb_fmt.sv
// Completion formatter: clips the frame to the buffer and builds the
// control word handed back to the host.
// Assumes size and length are byte counts of LEN_W bits.
module rxr_wb_fmt
    import rxr_pkg::*;
(
    input  logic [LEN_W-1:0] frame_len,
    input  logic [LEN_W-1:0] buf_size,
    input  logic             eor,
    output logic [LEN_W-1:0] xfer_len,
    output logic [31:0]      wb_word
);
    logic trunc;

    // Clip the transfer to the buffer and flag when clipping happened.
    always_comb begin
        trunc    = frame_len > buf_size;
        xfer_len = trunc ? buf_size : frame_len;
    end

    // Ownership back to host, ring-end kept, flag and count inserted.
    always_comb begin
        wb_word              = '0;
        wb_word[EOR_BIT]     = eor;
        wb_word[TRUNC_BIT]   = trunc;
        wb_word[LEN_W-1:0]   = xfer_len;
    end
endmodule

// File: rtl/rx_ring_mgr.sv
// Receive descriptor ring manager: per frame, fetches the current descriptor,
// checks ownership, hands the buffer to the write DMA and writes status back.
// Halts on a host-owned descriptor until restarted. Assumes one outstanding
// memory request at a time and read data valid with mem_ack.
module rx_ring_mgr
    import rxr_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int MAX_DESC = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [LEN_W-1:0]  max_rx_len,
    input  logic              restart,
    input  logic              frm_valid,
    input  logic [LEN_W-1:0]  frm_len,
    output logic              frm_ready,
    output logic              frm_drop,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              dma_req,
    output logic [BUF_AW-1:0] dma_addr,
    output logic [LEN_W-1:0]  dma_len,
    input  logic              dma_done,
    output logic              rdu_irq,
    output logic              halted,
    output logic              base_err
);
    rxr_state_t        st;
    logic [LEN_W-1:0]  len_q, size_q;
    logic              eor_q;
    logic [31:0]       lo_q, hi_q;
    logic              admit_ok, base_ok, ptr_load, ptr_adv;
    logic [ADDR_W-1:0] desc_addr;
    logic [31:0]       wb_word;

    always_comb base_ok  = (ring_base[ALIGN_SH-1:0] == '0);
    always_comb ptr_load = (st == S_OFF) && start && base_ok;
    always_comb ptr_adv  = (st == S_WB) && mem_ack;

    rxr_admit u_admit (
        .frm_len (frm_len),
        .max_len (max_rx_len),
        .ok      (admit_ok)
    );

    rxr_ring_ptr #(.ADDR_W(ADDR_W), .MAX_DESC(MAX_DESC)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ptr_load),
        .base_in   (ring_base),
        .advance   (ptr_adv),
        .wrap      (eor_q),
        .desc_addr (desc_addr)
    );

    rxr_wb_fmt u_fmt (
        .frame_len (len_q),
        .buf_size  (size_q),
        .eor       (eor_q),
        .xfer_len  (dma_len),
        .wb_word   (wb_word)
    );

    // Sequencer: admission, three descriptor reads, DMA, write-back, halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_OFF;
            len_q    <= '0;
            size_q   <= '0;
            eor_q    <= 1'b0;
            lo_q     <= '0;
            hi_q     <= '0;
            base_err <= 1'b0;
            rdu_irq  <= 1'b0;
            frm_drop <= 1'b0;
        end else begin
            rdu_irq  <= 1'b0;
            frm_drop <= 1'b0;
            case (st)
                S_OFF: if (start) begin
                    base_err <= !base_ok;
                    if (base_ok) st <= S_IDLE;
                end
                S_IDLE: if (frm_valid) begin
                    if (admit_ok) begin
                        len_q <= frm_len;
                        st    <= S_RD0;
                    end else begin
                        frm_drop <= 1'b1;
                    end
                end
                S_RD0: if (mem_ack) begin
                    if (!mem_rdata[OWN_BIT]) begin
                        rdu_irq <= 1'b1;
                        st      <= S_HALT;
                    end else begin
                        eor_q  <= mem_rdata[EOR_BIT];
                        size_q <= mem_rdata[LEN_W-1:0];
                        st     <= S_RDL;
                    end
                end
                S_RDL: if (mem_ack) begin
                    lo_q <= mem_rdata;
                    st   <= S_RDH;
                end
                S_RDH: if (mem_ack) begin
                    hi_q <= mem_rdata;
                    st   <= S_DMA;
                end
                S_DMA:  if (dma_done) st <= S_WB;
                S_WB:   if (mem_ack)  st <= S_IDLE;
                S_HALT: if (restart)  st <= S_RD0;
                default: st <= S_OFF;
            endcase
        end
    end

    // Port outputs decoded from the sequencer state.
    always_comb begin
        frm_ready = (st == S_IDLE);
        halted    = (st == S_HALT);
        dma_req   = (st == S_DMA);
        dma_addr  = {hi_q, lo_q};
        mem_req   = (st == S_RD0) || (st == S_RDL) || (st == S_RDH) || (st == S_WB);
        mem_we    = (st == S_WB);
        mem_wdata = (st == S_WB) ? wb_word : '0;
        case (st)
            S_RDL:   mem_addr = desc_addr + ADDR_W'(8);
            S_RDH:   mem_addr = desc_addr + ADDR_W'(12);
            default: mem_addr = desc_addr;
        endcase
    end
endmodule

// File: rtl/rxr_checker.sv
// Protocol checker for the receive descriptor ring manager, bound to the top.
// Assumes max_rx_len is held constant while a frame is in flight.
module rxr_checker
    import rxr_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frm_ready,
    input logic              frm_drop,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack,
    input logic              dma_req,
    input logic [LEN_W-1:0]  dma_len,
    input logic              dma_done,
    input logic [LEN_W-1:0]  max_rx_len,
    input logic              rdu_irq,
    input logic              halted,
    input logic              base_err
);
    p_err_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
        base_err |-> !frm_ready && !mem_req);

    p_drop_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_drop |-> !mem_req && !dma_req);

    p_dma_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && !dma_done |=> dma_req && $stable(dma_len));

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    p_wb_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[OWN_BIT]);

    p_dma_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> dma_len <= max_rx_len);

    p_irq_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rdu_irq |-> halted);

    p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req && !dma_req && !frm_ready);
endmodule

bind rx_ring_mgr rxr_checker #(.ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_ready  (frm_ready),
    .frm_drop   (frm_drop),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .dma_req    (dma_req),
    .dma_len    (dma_len),
    .dma_done   (dma_done),
    .max_rx_len (max_rx_len),
    .rdu_irq    (rdu_irq),
    .halted     (halted),
    .base_err   (base_err)
);

// File: tb/test_rx_ring_mgr.sv
module test_rx_ring_mgr;
    localparam logic [63:0] BASE = 64'h0000_0001_0000_0300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] ring_base = '0;
    logic [13:0] max_rx_len = 14'd1500;
    logic        restart = 1'b0;
    logic        frm_valid = 1'b0;
    logic [13:0] frm_len = '0;
    logic        frm_ready, frm_drop, mem_req, mem_we, dma_req, rdu_irq, halted, base_err;
    logic [63:0] mem_addr, dma_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [13:0] dma_len;
    logic        dma_done = 1'b0;

    always #2 clk = ~clk;

    rx_ring_mgr i_rx_ring_mgr (.*);

    typedef struct {
        logic [63:0] daddr;
        logic [13:0] dlen;
        logic [63:0] waddr;
        logic [31:0] wdata;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] mem [0:15];
    logic [13:0] dsize [0:3];
    logic        deor  [0:3];
    int total = 0, bad = 0;
    int n_req = 0, n_irq = 0, n_drop = 0, n_wb = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] lo_of(input int i); return 64'h0000_0A00 + 64'(i) * 64'h100; endfunction
    function automatic logic [63:0] hi_of(input int i); return 64'h0000_00B0 + 64'(i); endfunction

    // Host side: hand descriptor i to the controller.
    task automatic arm(input int i, input logic [13:0] size, input logic eor);
        mem[i*4+0] = {1'b1, eor, 16'h0, size};
        mem[i*4+1] = '0;
        mem[i*4+2] = lo_of(i);
        mem[i*4+3] = hi_of(i);
        dsize[i] = size;
        deor[i]  = eor;
    endtask

    // Driver: predict DMA hand-off and write-back for frame len into descriptor i.
    task automatic expect_desc(input int i, input logic [13:0] len);
        exp_t e;
        logic tr;
        logic [13:0] eff;
        tr  = len > dsize[i];
        eff = tr ? dsize[i] : len;
        e.daddr = {hi_of(i)[31:0], lo_of(i)[31:0]};
        e.dlen  = eff;
        e.waddr = BASE + 64'(i) * 64'd16;
        e.wdata = {1'b0, deor[i], 8'h0, tr, 7'h0, eff};
        sb.push_back(e);
    endtask

    // Offer a frame and wait until the engine is idle again or halted.
    task automatic send(input logic [13:0] len);
        @(negedge clk);
        frm_valid = 1'b1;
        frm_len   = len;
        while (!frm_ready) @(negedge clk);
        @(negedge clk);
        frm_valid = 1'b0;
        while (!(frm_ready || halted)) @(negedge clk);
    endtask

    // Memory responder and write-back monitor.
    initial forever begin
        @(negedge clk);
        if (mem_ack) mem_ack = 1'b0;
        else if (mem_req) begin
            logic [63:0] off;
            off = mem_addr - BASE;
            mem_ack = 1'b1;
            if (off >= 64) begin
                check(0, "R7 address in ring", mem_addr, BASE);
                mem_rdata = '0;
            end else if (mem_we) begin
                n_wb++;
                if (sb.size() == 0) check(0, "R5 unexpected write-back", mem_addr, 0);
                else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(mem_addr == e.waddr, "R7 write-back address", mem_addr, e.waddr);
                    check(mem_wdata == e.wdata, "R5 write-back word", 64'(mem_wdata), 64'(e.wdata));
                end
                mem[off[5:2]] = mem_wdata;
            end else mem_rdata = mem[off[5:2]];
        end
    end

    // DMA responder and hand-off monitor.
    initial forever begin
        @(negedge clk);
        if (dma_done) dma_done = 1'b0;
        else if (dma_req) begin
            dma_done = 1'b1;
            if (sb.size() == 0) check(0, "R3 unexpected DMA", dma_addr, 0);
            else begin
                check(dma_addr == sb[0].daddr, "R3 buffer address", dma_addr, sb[0].daddr);
                check(dma_len == sb[0].dlen, "R6 DMA length", 64'(dma_len), 64'(sb[0].dlen));
            end
        end
    end

    // Event counters sampled between edges.
    initial forever begin
        @(negedge clk);
        if (mem_req && !mem_ack) n_req++;
        if (rdu_irq) n_irq++;
        if (frm_drop) n_drop++;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int r0, w0;
        for (int i = 0; i < 16; i++) mem[i] = '0;
        arm(0, 14'd200, 1'b0);
        arm(1, 14'd256, 1'b0);
        arm(2, 14'd512, 1'b1);
        arm(3, 14'd64,  1'b0);          // decoy beyond the ring end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!frm_ready && !mem_req && !halted && !base_err, "reset state",
              {frm_ready, mem_req, halted, base_err}, 0);

        // R1: misaligned base is refused
        ring_base = BASE + 64'd4; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        check(base_err && !frm_ready && n_req == 0, "R1 misaligned base",
              {base_err, frm_ready}, 2'b10);
        ring_base = BASE; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        check(!base_err && frm_ready, "R1 aligned start", {base_err, frm_ready}, 2'b01);

        // R3 R5: fits in buffer
        expect_desc(0, 14'd100); send(14'd100);
        // R6: one byte over buffer size is truncated
        expect_desc(1, 14'd257); send(14'd257);
        // R6 R7: exactly buffer size, ring-end descriptor
        expect_desc(2, 14'd512); send(14'd512);
        check(sb.size() == 0 && n_wb == 3, "R5 three write-backs", 64'(n_wb), 3);
        check(mem[2*4] == {1'b0, 1'b1, 8'h0, 1'b0, 7'h0, 14'd512}, "R5 ring-end word kept",
              64'(mem[8]), 64'h4000_0200);

        // R7: wraps to base, not to the decoy; frame at the exact limit
        arm(0, 14'd200, 1'b0);
        expect_desc(0, 14'd1500); send(14'd1500);
        check(sb.size() == 0 && mem[12][31], "R7 wrap to base, decoy untouched",
              64'(mem[12]), 64'(mem[12] | 32'h8000_0000));

        // R8: descriptor 1 now host-owned -> halt
        w0 = n_wb;
        send(14'd64);
        repeat (3) @(negedge clk);
        check(halted && !frm_ready, "R8 halted", {halted, frm_ready}, 2'b10);
        check(n_irq == 1, "R8 one interrupt pulse", 64'(n_irq), 1);
        check(n_wb == w0, "R8 no write-back while halted", 64'(n_wb), 64'(w0));

        // R9: refill and restart, same descriptor receives the waiting frame
        arm(1, 14'd128, 1'b0);
        expect_desc(1, 14'd64);
        restart = 1'b1; @(negedge clk); restart = 1'b0;
        while (!frm_ready) @(negedge clk);
        check(sb.size() == 0 && n_wb == w0 + 1 && !halted, "R9 resumed on same descriptor",
              64'(n_wb), 64'(w0 + 1));

        // R2: oversize and zero-limit frames are dropped without memory traffic
        r0 = n_req;
        send(14'd1501);
        @(negedge clk);
        check(n_drop == 1 && n_req == r0, "R2 oversize dropped", 64'(n_drop), 1);
        max_rx_len = 14'd0;
        send(14'd1);
        @(negedge clk);
        check(n_drop == 2 && n_req == r0, "R2 zero limit drops", 64'(n_drop), 2);
        check(frm_ready && n_irq == 1, "R2 still ready after drops", 64'(frm_ready), 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule